// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard and flow controller of a five-stage RV32I pipeline. It looks at the decoded fields held in the IF/ID, ID/EX, EX/MEM and MEM/WB pipeline registers, and it drives the pipeline's control. It picks the forwarding source for each EX operand. It evaluates branch conditions in EX on the forwarded operand values. It stalls fetch and decode for one cycle when an instruction depends on a load that is still in EX. It flushes the two younger instructions behind a taken branch. It runs a short trap sequence for an environment call and raises the write strobes for the machine-mode exception registers during that sequence.

The datapath, register file, memories and ALU are not part of this block. The block receives operand values, results and PCs only so that it can compare branch operands and form the next fetch address. The next fetch address is the fetch PC plus 4, the branch target (branch PC plus immediate), or the trap vector.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each EX operand select is 2'b10 when the EX/MEM instruction writes the register that operand reads, 2'b01 when only the MEM/WB instruction does, and 2'b00 otherwise. When both stages match, EX/MEM wins.
- R2: No forwarding happens from a stage whose destination is x0 or whose write enable is low. The select stays 2'b00 in that case.
- R3: A branch in ID/EX (branch flag high) is decided on the forwarded operands. The funct3 codes are: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. Any other code is never taken, and nothing is taken while the branch flag is low.
- R4: A taken branch raises both the IF/ID and the ID/EX clears, keeps the PC write enable high, sets pc_sel to 2'b01, and makes next_pc equal the ID/EX PC plus the immediate.
- R5: With no hazard, branch or trap, every write enable is high, both clears are low, pc_sel is 2'b00 and next_pc is the fetch PC plus 4.
- R6: A load in ID/EX with a nonzero rd that equals rs1 or rs2 of the IF/ID instruction holds the PC and IF/ID (write enables low, IF/ID clear low) and clears ID/EX to a bubble. No stall happens when rd is x0 or when the ID/EX instruction is not a load.
- R7: If a taken branch and a load-use condition appear in the same cycle, the branch flush wins and no stall is raised.
- R8: An ecall in ID/EX, which outranks a branch there, freezes the PC, IF/ID and ID/EX for two cycles with both clears low. In the third cycle the controller raises both clears with the PC write enable, sets pc_sel to 2'b10, and makes next_pc the trap vector.
- R9: In the second frozen cycle of a trap, the mepc, mcause and mtval strobes are high for exactly that one cycle. The mepc value is the ID/EX PC captured when the ecall was first seen, mcause is 11 and mtval is 0.
- R10: Reset, even in the middle of a trap, returns the trap sequencer to idle. The controller then shows normal flow and drops the exception register strobes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | XLEN | PC of the instruction being fetched |
| ifid_rs1 | input | RW | rs1 field of the IF/ID instruction |
| ifid_rs2 | input | RW | rs2 field of the IF/ID instruction |
| idex_pc | input | XLEN | PC of the ID/EX instruction |
| idex_imm | input | XLEN | Branch immediate of the ID/EX instruction |
| idex_rs1 | input | RW | rs1 field in ID/EX |
| idex_rs2 | input | RW | rs2 field in ID/EX |
| idex_rd | input | RW | rd field in ID/EX |
| idex_rs1_val | input | XLEN | Register file value for rs1 |
| idex_rs2_val | input | XLEN | Register file value for rs2 |
| idex_is_load | input | 1 | ID/EX holds a load |
| idex_is_branch | input | 1 | ID/EX holds a conditional branch |
| idex_funct3 | input | 3 | Branch condition code |
| idex_is_ecall | input | 1 | ID/EX holds an ecall |
| exmem_rd | input | RW | Destination in EX/MEM |
| exmem_wen | input | 1 | EX/MEM writes a register |
| exmem_result | input | XLEN | EX/MEM result value |
| memwb_rd | input | RW | Destination in MEM/WB |
| memwb_wen | input | 1 | MEM/WB writes a register |
| memwb_result | input | XLEN | MEM/WB write-back value |
| trap_vec | input | XLEN | Trap vector base (mtvec contents) |
| fwd_a_sel | output | 2 | Operand A source select |
| fwd_b_sel | output | 2 | Operand B source select |
| br_taken | output | 1 | Branch in EX is taken |
| pc_we | output | 1 | PC write enable |
| pc_sel | output | 2 | 00 sequential, 01 branch, 10 trap |
| next_pc | output | XLEN | Next fetch address |
| ifid_we | output | 1 | IF/ID write enable |
| ifid_clr | output | 1 | IF/ID clear |
| idex_we | output | 1 | ID/EX write enable |
| idex_clr | output | 1 | ID/EX clear |
| mepc_we | output | 1 | mepc write strobe |
| mcause_we | output | 1 | mcause write strobe |
| mtval_we | output | 1 | mtval write strobe |
| mepc_d | output | XLEN | mepc write data |
| mcause_d | output | XLEN | mcause write data |
| mtval_d | output | XLEN | mtval write data |

## Verification
Forwarding is tried with a source matching only EX/MEM or only MEM/WB, both matching at once, x0 destinations, and a matching destination with its write enable low. These cases separate priority from plain matching. Branches use operand pairs such as 5 against 0xFFFFFFFD, which flip outcome between the signed and unsigned codes. Other cases are right only when the forwarded value is used rather than the register value, which exposes a compare on the wrong operand. Load-use cases cover a match on rs1, a match on rs2, an x0 destination, a non-load and a coincident taken branch. The trap is walked cycle by cycle with the ID/EX PC changed mid-sequence, to show that mepc is captured at detection, and then interrupted by reset.

// File: rtl/pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl #(
  parameter int XLEN       = 32,
  parameter int RW         = 5,
  parameter int TRAP_CAUSE = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic [RW-1:0]   ifid_rs1,
  input  logic [RW-1:0]   ifid_rs2,
  input  logic [XLEN-1:0] idex_pc,
  input  logic [XLEN-1:0] idex_imm,
  input  logic [RW-1:0]   idex_rs1,
  input  logic [RW-1:0]   idex_rs2,
  input  logic [RW-1:0]   idex_rd,
  input  logic [XLEN-1:0] idex_rs1_val,
  input  logic [XLEN-1:0] idex_rs2_val,
  input  logic            idex_is_load,
  input  logic            idex_is_branch,
  input  logic [2:0]      idex_funct3,
  input  logic            idex_is_ecall,
  input  logic [RW-1:0]   exmem_rd,
  input  logic            exmem_wen,
  input  logic [XLEN-1:0] exmem_result,
  input  logic [RW-1:0]   memwb_rd,
  input  logic            memwb_wen,
  input  logic [XLEN-1:0] memwb_result,
  input  logic [XLEN-1:0] trap_vec,
  output logic [1:0]      fwd_a_sel,
  output logic [1:0]      fwd_b_sel,
  output logic            br_taken,
  output logic            pc_we,
  output logic [1:0]      pc_sel,
  output logic [XLEN-1:0] next_pc,
  output logic            ifid_we,
  output logic            ifid_clr,
  output logic            idex_we,
  output logic            idex_clr,
  output logic            mepc_we,
  output logic            mcause_we,
  output logic            mtval_we,
  output logic [XLEN-1:0] mepc_d,
  output logic [XLEN-1:0] mcause_d,
  output logic [XLEN-1:0] mtval_d
);

  localparam logic [1:0] SEL_REG = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  localparam logic [1:0] PC_SEQ  = 2'b00;
  localparam logic [1:0] PC_BR   = 2'b01;
  localparam logic [1:0] PC_TRAP = 2'b10;

  typedef enum logic [1:0] {TR_IDLE = 2'd0, TR_WRITE = 2'd1, TR_JUMP = 2'd2} trap_t;

  trap_t           st;
  logic [XLEN-1:0] epc_q;
  logic [XLEN-1:0] op_a, op_b;
  logic            cond;
  logic            trap_start, trap_hold, trap_jump;
  logic            load_use, lu_stall;

  function automatic logic [1:0] pick_src(input logic [RW-1:0] src);
    if (exmem_wen && exmem_rd != '0 && exmem_rd == src)
      return SEL_MEM;
    else if (memwb_wen && memwb_rd != '0 && memwb_rd == src)
      return SEL_WB;
    else
      return SEL_REG;
  endfunction

  assign fwd_a_sel = pick_src(idex_rs1);
  assign fwd_b_sel = pick_src(idex_rs2);

  assign op_a = (fwd_a_sel == SEL_MEM) ? exmem_result :
                (fwd_a_sel == SEL_WB)  ? memwb_result : idex_rs1_val;
  assign op_b = (fwd_b_sel == SEL_MEM) ? exmem_result :
                (fwd_b_sel == SEL_WB)  ? memwb_result : idex_rs2_val;

  always_comb begin
    case (idex_funct3)
      3'b000:  cond = (op_a == op_b);
      3'b001:  cond = (op_a != op_b);
      3'b100:  cond = ($signed(op_a) <  $signed(op_b));
      3'b101:  cond = ($signed(op_a) >= $signed(op_b));
      3'b110:  cond = (op_a <  op_b);
      3'b111:  cond = (op_a >= op_b);
      default: cond = 1'b0;
    endcase
  end

  assign trap_start = (st == TR_IDLE) && idex_is_ecall;
  assign trap_hold  = trap_start || (st == TR_WRITE);
  assign trap_jump  = (st == TR_JUMP);

  assign br_taken = idex_is_branch && cond && (st == TR_IDLE) && !idex_is_ecall;

  assign load_use = idex_is_load && idex_rd != '0 &&
                    (idex_rd == ifid_rs1 || idex_rd == ifid_rs2);
  assign lu_stall = load_use && !br_taken && !trap_hold && !trap_jump;

  assign pc_we    = !(trap_hold || lu_stall);
  assign ifid_we  = !(trap_hold || lu_stall);
  assign idex_we  = !trap_hold;
  assign ifid_clr = br_taken || trap_jump;
  assign idex_clr = br_taken || trap_jump || lu_stall;

  assign pc_sel = trap_jump ? PC_TRAP : (br_taken ? PC_BR : PC_SEQ);

  always_comb begin
    case (pc_sel)
      PC_BR:   next_pc = idex_pc + idex_imm;
      PC_TRAP: next_pc = trap_vec;
      default: next_pc = fetch_pc + XLEN'(4);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= TR_IDLE;
      epc_q <= '0;
    end else begin
      case (st)
        TR_IDLE: if (idex_is_ecall) begin
          st    <= TR_WRITE;
          epc_q <= idex_pc;
        end
        TR_WRITE: st <= TR_JUMP;
        default:  st <= TR_IDLE;
      endcase
    end
  end

  assign mepc_we   = (st == TR_WRITE);
  assign mcause_we = (st == TR_WRITE);
  assign mtval_we  = (st == TR_WRITE);
  assign mepc_d    = epc_q;
  assign mcause_d  = XLEN'(TRAP_CAUSE);
  assign mtval_d   = '0;

endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_chk #(
  parameter int XLEN = 32,
  parameter int RW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] fetch_pc,
  input logic [RW-1:0]   ifid_rs1,
  input logic [XLEN-1:0] idex_pc,
  input logic [RW-1:0]   idex_rs1,
  input logic [RW-1:0]   idex_rd,
  input logic            idex_is_load,
  input logic            idex_is_branch,
  input logic            idex_is_ecall,
  input logic [RW-1:0]   exmem_rd,
  input logic            exmem_wen,
  input logic [1:0]      st,
  input logic [1:0]      fwd_a_sel,
  input logic [1:0]      fwd_b_sel,
  input logic            br_taken,
  input logic            pc_we,
  input logic [1:0]      pc_sel,
  input logic [XLEN-1:0] next_pc,
  input logic            ifid_we,
  input logic            ifid_clr,
  input logic            idex_we,
  input logic            idex_clr,
  input logic            mepc_we,
  input logic            mcause_we,
  input logic            mtval_we,
  input logic [XLEN-1:0] mepc_d,
  input logic [XLEN-1:0] mcause_d,
  input logic [XLEN-1:0] mtval_d
);

  assert_fwd_mem_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_wen && exmem_rd != '0 && exmem_rd == idex_rs1) |-> fwd_a_sel == 2'b10);

  assert_fwd_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11);

  assert_no_x0_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_rs1 == '0) |-> fwd_a_sel == 2'b00);

  assert_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (ifid_clr && idex_clr && pc_we && pc_sel == 2'b01));

  assert_seq_flow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!idex_is_load && !idex_is_branch && !idex_is_ecall && st == 2'd0) |->
      (pc_we && ifid_we && idex_we && !ifid_clr && !idex_clr &&
       pc_sel == 2'b00 && next_pc == fetch_pc + XLEN'(4)));

  assert_lu_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_is_load && idex_rd != '0 && idex_rd == ifid_rs1 && !br_taken &&
     !idex_is_ecall && st == 2'd0) |-> (!pc_we && !ifid_we && idex_clr && !ifid_clr));

  assert_br_over_lu_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && idex_is_load) |-> (pc_we && ifid_we));

  assert_trap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mepc_we |-> (!pc_we && !ifid_we && !idex_we && !ifid_clr && !idex_clr));

  assert_trap_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mepc_we |=> (pc_sel == 2'b10 && pc_we && ifid_clr && idex_clr));

  assert_csr_values_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mepc_we |-> (mcause_we && mtval_we && mcause_d == XLEN'(11) && mtval_d == '0));

  assert_csr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mepc_we |=> !mepc_we);

  assert_epc_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mepc_we |-> mepc_d == $past(idex_pc));

endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.XLEN(XLEN), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .ifid_rs1(ifid_rs1),
  .idex_pc(idex_pc), .idex_rs1(idex_rs1), .idex_rd(idex_rd),
  .idex_is_load(idex_is_load), .idex_is_branch(idex_is_branch),
  .idex_is_ecall(idex_is_ecall), .exmem_rd(exmem_rd), .exmem_wen(exmem_wen),
  .st(st), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .br_taken(br_taken),
  .pc_we(pc_we), .pc_sel(pc_sel), .next_pc(next_pc), .ifid_we(ifid_we),
  .ifid_clr(ifid_clr), .idex_we(idex_we), .idex_clr(idex_clr),
  .mepc_we(mepc_we), .mcause_we(mcause_we), .mtval_we(mtval_we),
  .mepc_d(mepc_d), .mcause_d(mcause_d), .mtval_d(mtval_d)
);

// File: tb/sim_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_pipe_hazard_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc, idex_pc, idex_imm, idex_rs1_val, idex_rs2_val;
  logic [31:0] exmem_result, memwb_result, trap_vec;
  logic [4:0]  ifid_rs1, ifid_rs2, idex_rs1, idex_rs2, idex_rd, exmem_rd, memwb_rd;
  logic        idex_is_load, idex_is_branch, idex_is_ecall, exmem_wen, memwb_wen;
  logic [2:0]  idex_funct3;
  logic [1:0]  fwd_a_sel, fwd_b_sel, pc_sel;
  logic        br_taken, pc_we, ifid_we, ifid_clr, idex_we, idex_clr;
  logic        mepc_we, mcause_we, mtval_we;
  logic [31:0] next_pc, mepc_d, mcause_d, mtval_d;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pipe_hazard_ctrl u0 (.*);

  typedef struct packed {
    logic [7:0]  req;
    logic [4:0]  f_rs1, f_rs2, x_rs1, x_rs2, x_rd;
    logic        ld, br;
    logic [2:0]  f3;
    logic [31:0] a, b;
    logic [4:0]  m_rd;
    logic        m_we;
    logic [31:0] m_v;
    logic [4:0]  w_rd;
    logic        w_we;
    logic [31:0] w_v;
    logic [1:0]  e_fa, e_fb;
    logic        e_tk, e_pcwe, e_ifwe, e_ifclr, e_idclr;
    logic [1:0]  e_sel;
    logic [31:0] e_npc;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R5 idle flow
    '{8'd5, 5'd0,5'd0,5'd0,5'd0,5'd0, 1'b0,1'b0,3'd0, 32'd0,32'd0, 5'd0,1'b0,32'd0, 5'd0,1'b0,32'd0,
      2'd0,2'd0, 1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 32'h104},
    // R1 split sources
    '{8'd1, 5'd0,5'd0,5'd5,5'd6,5'd0, 1'b0,1'b0,3'd0, 32'd0,32'd0, 5'd5,1'b1,32'd0, 5'd6,1'b1,32'd0,
      2'd2,2'd1, 1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 32'h104},
    // R1 both match, EX/MEM wins
    '{8'd1, 5'd0,5'd0,5'd7,5'd7,5'd0, 1'b0,1'b0,3'd0, 32'd0,32'd0, 5'd7,1'b1,32'd0, 5'd7,1'b1,32'd0,
      2'd2,2'd2, 1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 32'h104},
    // R2 x0 destination
    '{8'd2, 5'd0,5'd0,5'd0,5'd0,5'd0, 1'b0,1'b0,3'd0, 32'd0,32'd0, 5'd0,1'b1,32'd0, 5'd0,1'b1,32'd0,
      2'd0,2'd0, 1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 32'h104},
    // R2 EX/MEM write enable low
    '{8'd2, 5'd0,5'd0,5'd3,5'd4,5'd0, 1'b0,1'b0,3'd0, 32'd0,32'd0, 5'd3,1'b0,32'd0, 5'd3,1'b1,32'd0,
      2'd1,2'd0, 1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 32'h104},
    // R4 signed bge taken
    '{8'd4, 5'd0,5'd0,5'd0,5'd0,5'd0, 1'b0,1'b1,3'd5, 32'd5,32'hFFFF_FFFD, 5'd0,1'b0,32'd0, 5'd0,1'b0,32'd0,
      2'd0,2'd0, 1'b1,1'b1,1'b1,1'b1,1'b1, 2'd1, 32'hC0},
    // R3 bgeu same operands not taken
    '{8'd3, 5'd0,5'd0,5'd0,5'd0,5'd0, 1'b0,1'b1,3'd7, 32'd5,32'hFFFF_FFFD, 5'd0,1'b0,32'd0, 5'd0,1'b0,32'd0,
      2'd0,2'd0, 1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 32'h104},
    // R3 blt on forwarded EX/MEM value
    '{8'd3, 5'd0,5'd0,5'd8,5'd0,5'd0, 1'b0,1'b1,3'd4, 32'd100,32'd1, 5'd8,1'b1,32'hFFFF_FFF0, 5'd0,1'b0,32'd0,
      2'd2,2'd0, 1'b1,1'b1,1'b1,1'b1,1'b1, 2'd1, 32'hC0},
    // R3 beq on forwarded MEM/WB value
    '{8'd3, 5'd0,5'd0,5'd0,5'd9,5'd0, 1'b0,1'b1,3'd0, 32'd42,32'd0, 5'd0,1'b0,32'd0, 5'd9,1'b1,32'd42,
      2'd0,2'd1, 1'b1,1'b1,1'b1,1'b1,1'b1, 2'd1, 32'hC0},
    // R3 bne equal not taken
    '{8'd3, 5'd0,5'd0,5'd0,5'd0,5'd0, 1'b0,1'b1,3'd1, 32'd7,32'd7, 5'd0,1'b0,32'd0, 5'd0,1'b0,32'd0,
      2'd0,2'd0, 1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 32'h104},
    // R3 branch flag low
    '{8'd3, 5'd0,5'd0,5'd0,5'd0,5'd0, 1'b0,1'b0,3'd0, 32'd7,32'd7, 5'd0,1'b0,32'd0, 5'd0,1'b0,32'd0,
      2'd0,2'd0, 1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 32'h104},
    // R6 load-use on rs1
    '{8'd6, 5'd4,5'd0,5'd0,5'd0,5'd4, 1'b1,1'b0,3'd0, 32'd0,32'd0, 5'd0,1'b0,32'd0, 5'd0,1'b0,32'd0,
      2'd0,2'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0, 32'h104},
    // R6 load-use on rs2
    '{8'd6, 5'd0,5'd4,5'd0,5'd0,5'd4, 1'b1,1'b0,3'd0, 32'd0,32'd0, 5'd0,1'b0,32'd0, 5'd0,1'b0,32'd0,
      2'd0,2'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 2'd0, 32'h104},
    // R6 load to x0
    '{8'd6, 5'd0,5'd0,5'd0,5'd0,5'd0, 1'b1,1'b0,3'd0, 32'd0,32'd0, 5'd0,1'b0,32'd0, 5'd0,1'b0,32'd0,
      2'd0,2'd0, 1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 32'h104},
    // R6 not a load
    '{8'd6, 5'd4,5'd0,5'd0,5'd0,5'd4, 1'b0,1'b0,3'd0, 32'd0,32'd0, 5'd0,1'b0,32'd0, 5'd0,1'b0,32'd0,
      2'd0,2'd0, 1'b0,1'b1,1'b1,1'b0,1'b0, 2'd0, 32'h104},
    // R7 branch beats load-use
    '{8'd7, 5'd4,5'd0,5'd0,5'd0,5'd4, 1'b1,1'b1,3'd0, 32'd1,32'd1, 5'd0,1'b0,32'd0, 5'd0,1'b0,32'd0,
      2'd0,2'd0, 1'b1,1'b1,1'b1,1'b1,1'b1, 2'd1, 32'hC0},
    // R3 bltu taken
    '{8'd3, 5'd0,5'd0,5'd0,5'd0,5'd0, 1'b0,1'b1,3'd6, 32'd5,32'hFFFF_FFFD, 5'd0,1'b0,32'd0, 5'd0,1'b0,32'd0,
      2'd0,2'd0, 1'b1,1'b1,1'b1,1'b1,1'b1, 2'd1, 32'hC0}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic defaults();
    fetch_pc = 32'h100; idex_pc = 32'h80; idex_imm = 32'h40; trap_vec = 32'h200;
    ifid_rs1 = '0; ifid_rs2 = '0; idex_rs1 = '0; idex_rs2 = '0; idex_rd = '0;
    idex_rs1_val = '0; idex_rs2_val = '0; idex_is_load = 1'b0; idex_is_branch = 1'b0;
    idex_funct3 = '0; idex_is_ecall = 1'b0;
    exmem_rd = '0; exmem_wen = 1'b0; exmem_result = '0;
    memwb_rd = '0; memwb_wen = 1'b0; memwb_result = '0;
  endtask

  task automatic flow_ok(input string tag);
    chk({tag, " pc_we"}, 32'(pc_we), 32'd1);
    chk({tag, " ifid_we"}, 32'(ifid_we), 32'd1);
    chk({tag, " idex_we"}, 32'(idex_we), 32'd1);
    chk({tag, " pc_sel"}, 32'(pc_sel), 32'd0);
    chk({tag, " next_pc"}, next_pc, 32'h104);
    chk({tag, " mepc_we"}, 32'(mepc_we), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    defaults();
    repeat (3) @(negedge clk);
    #1;
    flow_ok("R10 reset");
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      defaults();
      ifid_rs1 = VECS[i].f_rs1; ifid_rs2 = VECS[i].f_rs2;
      idex_rs1 = VECS[i].x_rs1; idex_rs2 = VECS[i].x_rs2; idex_rd = VECS[i].x_rd;
      idex_is_load = VECS[i].ld; idex_is_branch = VECS[i].br; idex_funct3 = VECS[i].f3;
      idex_rs1_val = VECS[i].a; idex_rs2_val = VECS[i].b;
      exmem_rd = VECS[i].m_rd; exmem_wen = VECS[i].m_we; exmem_result = VECS[i].m_v;
      memwb_rd = VECS[i].w_rd; memwb_wen = VECS[i].w_we; memwb_result = VECS[i].w_v;
      #1;
      chk($sformatf("R%0d vec %0d fwd_a", VECS[i].req, i), 32'(fwd_a_sel), 32'(VECS[i].e_fa));
      chk($sformatf("R%0d vec %0d fwd_b", VECS[i].req, i), 32'(fwd_b_sel), 32'(VECS[i].e_fb));
      chk($sformatf("R%0d vec %0d taken", VECS[i].req, i), 32'(br_taken), 32'(VECS[i].e_tk));
      chk($sformatf("R%0d vec %0d pc_we", VECS[i].req, i), 32'(pc_we), 32'(VECS[i].e_pcwe));
      chk($sformatf("R%0d vec %0d ifid_we", VECS[i].req, i), 32'(ifid_we), 32'(VECS[i].e_ifwe));
      chk($sformatf("R%0d vec %0d ifid_clr", VECS[i].req, i), 32'(ifid_clr), 32'(VECS[i].e_ifclr));
      chk($sformatf("R%0d vec %0d idex_clr", VECS[i].req, i), 32'(idex_clr), 32'(VECS[i].e_idclr));
      chk($sformatf("R%0d vec %0d idex_we", VECS[i].req, i), 32'(idex_we), 32'd1);
      chk($sformatf("R%0d vec %0d pc_sel", VECS[i].req, i), 32'(pc_sel), 32'(VECS[i].e_sel));
      chk($sformatf("R%0d vec %0d next_pc", VECS[i].req, i), next_pc, VECS[i].e_npc);
    end

    // R6: stall lasts one cycle; bubble in ID/EX removes the hazard
    @(negedge clk);
    defaults();
    idex_is_load = 1'b1; idex_rd = 5'd12; ifid_rs2 = 5'd12;
    #1 chk("R6 stall cycle pc_we", 32'(pc_we), 32'd0);
    @(negedge clk);
    idex_is_load = 1'b0; idex_rd = '0;
    #1 flow_ok("R6 after bubble");

    // R8/R9: ecall sequence, with a taken branch presented alongside it
    @(negedge clk);
    defaults();
    idex_is_ecall = 1'b1; idex_pc = 32'h300;
    idex_is_branch = 1'b1; idex_funct3 = 3'd0;
    #1;
    chk("R8 first hold taken", 32'(br_taken), 32'd0);
    chk("R8 first hold pc_we", 32'(pc_we), 32'd0);
    chk("R8 first hold ifid_we", 32'(ifid_we), 32'd0);
    chk("R8 first hold idex_we", 32'(idex_we), 32'd0);
    chk("R8 first hold clears", 32'({ifid_clr, idex_clr}), 32'd0);
    chk("R9 no strobe first hold", 32'({mepc_we, mcause_we, mtval_we}), 32'd0);
    @(negedge clk);
    idex_pc = 32'h344;
    #1;
    chk("R8 second hold pc_we", 32'(pc_we), 32'd0);
    chk("R8 second hold idex_we", 32'(idex_we), 32'd0);
    chk("R8 second hold clears", 32'({ifid_clr, idex_clr}), 32'd0);
    chk("R9 strobes", 32'({mepc_we, mcause_we, mtval_we}), 32'd7);
    chk("R9 mepc", mepc_d, 32'h300);
    chk("R9 mcause", mcause_d, 32'd11);
    chk("R9 mtval", mtval_d, 32'd0);
    @(negedge clk);
    #1;
    chk("R8 redirect pc_sel", 32'(pc_sel), 32'd2);
    chk("R8 redirect next_pc", next_pc, 32'h200);
    chk("R8 redirect pc_we", 32'(pc_we), 32'd1);
    chk("R8 redirect clears", 32'({ifid_clr, idex_clr}), 32'd3);
    chk("R9 strobe single", 32'(mepc_we), 32'd0);
    @(negedge clk);
    defaults();
    #1 flow_ok("R8 after trap");

    // R10: reset in the middle of a trap
    @(negedge clk);
    idex_is_ecall = 1'b1;
    @(negedge clk);
    #1 chk("R10 pre-reset strobe", 32'(mepc_we), 32'd1);
    rst_n = 1'b0;
    idex_is_ecall = 1'b0;
    #1 flow_ok("R10 mid-trap reset");
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    #1 flow_ok("R10 after release");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule